// File: doc/BRIEF.md
# DRAM Periodic Refresh Sequencer

This block keeps one DRAM rank refreshed on a fixed schedule. A down-counter measures the refresh interval; when it runs out while the rank is in normal operation, the sequencer takes the rank out of service. It waits for every in-flight access to finish. It wakes the rank if the rank sits in power-down, closes any open banks with a precharge-all command, and sends the refresh command. It then holds the rank for the refresh cycle time before handing it back to the scheduler.

The scheduler observes one flag, `burst_ok_o`, which is high only while the sequencer is idle; read and write bursts must be held whenever it is low. The memory controller reports the outstanding-access count, whether any bank is open, and whether the rank is in power-down. It also sends a request to fall into self-refresh after the current refresh, and a done indication once a later self-refresh exit has completed. The wake, precharge-all and refresh outputs are one-cycle command pulses. The interval, the precharge time and the refresh cycle time are parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `burst_ok_o` is 1 and `wake_o`, `prech_all_o` and `refresh_o` are 0.
- R2: With no outstanding accesses, no open bank and no power-down, the first `refresh_o` pulse comes INTERVAL_CYC+2 cycles after reset release, and later pulses follow every INTERVAL_CYC+2 cycles.
- R3: The sequence waits while `outstanding_i` is nonzero. No command pulse is issued until the count is zero, and the wake check follows in the cycle after the count is seen as zero.
- R4: If `powered_down_i` is 1 when the drain completes, a single `wake_o` pulse appears in the next cycle. The sequence then waits until `powered_down_i` returns to 0.
- R5: If `banks_open_i` is 1 at the wake check, `prech_all_o` pulses and `refresh_o` follows exactly PRECH_CYC cycles later. Otherwise no precharge-all is issued and `refresh_o` comes in the cycle after the wake check.
- R6: After a `refresh_o` pulse, `burst_ok_o` stays 0 for RFC_CYC further cycles and returns to 1 RFC_CYC+1 cycles after the pulse.
- R7: If `sref_req_i` is 1 in the last cycle of the refresh cycle time, `burst_ok_o` stays 0 until `sref_exit_done_i` is seen. A new sequence then starts at the drain step, so `refresh_o` follows 3 cycles after the done cycle when nothing else is pending.
- R8: `burst_ok_o` is 0 in every step of the sequence from the first drain cycle on, and is never 1 together with a command pulse.
- R9: Each of `wake_o`, `prech_all_o` and `refresh_o` is high for exactly one cycle per issue.
- R10: The interval counter reloads in the cycle `refresh_o` is issued, so the next drain starts INTERVAL_CYC cycles after every refresh, including one that follows a self-refresh exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| outstanding_i | input | OUT_W | Number of accesses still in flight to the rank |
| banks_open_i | input | 1 | At least one bank of the rank holds an open row |
| powered_down_i | input | 1 | Rank is in a power-down state |
| sref_req_i | input | 1 | Enter self-refresh once the current refresh completes |
| sref_exit_done_i | input | 1 | Self-refresh exit has completed |
| wake_o | output | 1 | One-cycle power-down exit command |
| prech_all_o | output | 1 | One-cycle precharge-all command |
| refresh_o | output | 1 | One-cycle refresh command |
| burst_ok_o | output | 1 | Read/write bursts may issue |

## Verification
The refresh sequence is run with a quiet rank, with open banks, with a nonzero outstanding count that falls late, with the rank powered down, with power-down and open banks together, and with a self-refresh request followed by a delayed exit. Each pattern predicts a different set of command pulses with distinct spacing. A missing or extra precharge, a wake pulse that ignores the power-down input, or a refresh issued before the drain finishes therefore shows up as a kind or cycle mismatch. The final quiet refresh after the self-refresh exit separates a counter that reloads on every refresh from one that keeps the older deadline.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_DRAIN,
        RS_WAKE,
        RS_SRX,
        RS_PRECH,
        RS_ISSUE,
        RS_RUN
    } rs_state_e;

    typedef struct packed {
        rs_state_e state;
        logic      wake;
        logic      prech;
        logic      refresh;
    } rs_fsm_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int INTERVAL_CYC = 7800,
    parameter int W            = $clog2(INTERVAL_CYC + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic reload_i,
    output logic expired_o
);

    localparam logic [W-1:0] RELOAD_VAL = W'(INTERVAL_CYC - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload_i) begin
            cnt_d = RELOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= RELOAD_VAL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ref_delay_timer.sv
module ref_delay_timer #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
    import ref_seq_pkg::*;
#(
    parameter int PRECH_CYC = 14,
    parameter int RFC_CYC   = 280,
    parameter int OUT_W     = 6,
    parameter int DLY_W     = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [OUT_W-1:0] outstanding_i,
    input  logic             banks_open_i,
    input  logic             powered_down_i,
    input  logic             sref_req_i,
    input  logic             sref_exit_done_i,
    input  logic             ivl_expired_i,
    input  logic             dly_done_i,
    output logic             ivl_reload_o,
    output logic             dly_load_o,
    output logic [DLY_W-1:0] dly_val_o,
    output logic             wake_o,
    output logic             prech_o,
    output logic             refresh_o,
    output logic             burst_ok_o
);

    localparam logic [DLY_W-1:0] PRECH_LOAD = DLY_W'(PRECH_CYC - 1);
    localparam logic [DLY_W-1:0] RFC_LOAD   = DLY_W'(RFC_CYC - 1);

    rs_fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d         = fsm_q;
        fsm_d.wake    = 1'b0;
        fsm_d.prech   = 1'b0;
        fsm_d.refresh = 1'b0;
        ivl_reload_o  = 1'b0;
        dly_load_o    = 1'b0;
        dly_val_o     = '0;

        unique case (fsm_q.state)
            RS_IDLE: begin
                if (ivl_expired_i) begin
                    fsm_d.state = RS_DRAIN;
                end
            end
            RS_DRAIN: begin
                if (outstanding_i == '0) begin
                    fsm_d.state = RS_WAKE;
                    fsm_d.wake  = powered_down_i;
                end
            end
            RS_WAKE: begin
                if (!powered_down_i) begin
                    if (banks_open_i) begin
                        fsm_d.state = RS_PRECH;
                        fsm_d.prech = 1'b1;
                        dly_load_o  = 1'b1;
                        dly_val_o   = PRECH_LOAD;
                    end else begin
                        fsm_d.state   = RS_ISSUE;
                        fsm_d.refresh = 1'b1;
                        ivl_reload_o  = 1'b1;
                    end
                end
            end
            RS_PRECH: begin
                if (dly_done_i) begin
                    fsm_d.state   = RS_ISSUE;
                    fsm_d.refresh = 1'b1;
                    ivl_reload_o  = 1'b1;
                end
            end
            RS_ISSUE: begin
                fsm_d.state = RS_RUN;
                dly_load_o  = 1'b1;
                dly_val_o   = RFC_LOAD;
            end
            RS_RUN: begin
                if (dly_done_i) begin
                    fsm_d.state = sref_req_i ? RS_SRX : RS_IDLE;
                end
            end
            RS_SRX: begin
                if (sref_exit_done_i) begin
                    fsm_d.state = RS_DRAIN;
                end
            end
            default: begin
                fsm_d.state = RS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fsm_q.state   <= RS_IDLE;
            fsm_q.wake    <= 1'b0;
            fsm_q.prech   <= 1'b0;
            fsm_q.refresh <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign wake_o     = fsm_q.wake;
    assign prech_o    = fsm_q.prech;
    assign refresh_o  = fsm_q.refresh;
    assign burst_ok_o = (fsm_q.state == RS_IDLE);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int INTERVAL_CYC = 7800,
    parameter int PRECH_CYC    = 14,
    parameter int RFC_CYC      = 280,
    parameter int OUT_W        = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [OUT_W-1:0] outstanding_i,
    input  logic             banks_open_i,
    input  logic             powered_down_i,
    input  logic             sref_req_i,
    input  logic             sref_exit_done_i,
    output logic             wake_o,
    output logic             prech_all_o,
    output logic             refresh_o,
    output logic             burst_ok_o
);

    localparam int DLY_MAX = (PRECH_CYC > RFC_CYC) ? PRECH_CYC : RFC_CYC;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int IVL_W   = $clog2(INTERVAL_CYC + 1);

    logic             ivl_reload;
    logic             ivl_expired;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_done;

    ref_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .W            (IVL_W)
    ) u_ivl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reload_i  (ivl_reload),
        .expired_o (ivl_expired)
    );

    ref_delay_timer #(
        .W (DLY_W)
    ) u_dly (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (dly_load),
        .load_val_i (dly_val),
        .done_o     (dly_done)
    );

    ref_seq_fsm #(
        .PRECH_CYC (PRECH_CYC),
        .RFC_CYC   (RFC_CYC),
        .OUT_W     (OUT_W),
        .DLY_W     (DLY_W)
    ) u_fsm (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .outstanding_i    (outstanding_i),
        .banks_open_i     (banks_open_i),
        .powered_down_i   (powered_down_i),
        .sref_req_i       (sref_req_i),
        .sref_exit_done_i (sref_exit_done_i),
        .ivl_expired_i    (ivl_expired),
        .dly_done_i       (dly_done),
        .ivl_reload_o     (ivl_reload),
        .dly_load_o       (dly_load),
        .dly_val_o        (dly_val),
        .wake_o           (wake_o),
        .prech_o          (prech_all_o),
        .refresh_o        (refresh_o),
        .burst_ok_o       (burst_ok_o)
    );

endmodule

// File: rtl/ref_seq_chk.sv
module ref_seq_chk #(
    parameter int PRECH_CYC = 14,
    parameter int RFC_CYC   = 280
) (
    input logic clk_i,
    input logic rst_ni,
    input logic powered_down_i,
    input logic wake_o,
    input logic prech_all_o,
    input logic refresh_o,
    input logic burst_ok_o
);

    localparam int SR_W = $clog2(RFC_CYC + 2);
    localparam int GP_W = $clog2(PRECH_CYC + 2);
    localparam logic [SR_W-1:0] SR_SAT = SR_W'(RFC_CYC + 1);
    localparam logic [GP_W-1:0] GP_SAT = GP_W'(PRECH_CYC + 1);

    logic [SR_W-1:0] since_ref_q;
    logic [GP_W-1:0] gap_q;
    logic            pend_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_ref_q <= SR_SAT;
            gap_q       <= GP_SAT;
            pend_q      <= 1'b0;
        end else begin
            if (refresh_o) begin
                since_ref_q <= SR_W'(1);
            end else if (since_ref_q != SR_SAT) begin
                since_ref_q <= since_ref_q + 1'b1;
            end
            if (prech_all_o) begin
                gap_q <= GP_W'(1);
            end else if (gap_q != GP_SAT) begin
                gap_q <= gap_q + 1'b1;
            end
            if (prech_all_o) begin
                pend_q <= 1'b1;
            end else if (refresh_o) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R9
    a_r9_refresh_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_o |=> !refresh_o);
    a_r9_prech_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prech_all_o |=> !prech_all_o);
    a_r9_wake_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    // R8
    a_r8_no_burst_with_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_o || prech_all_o || refresh_o) |-> !burst_ok_o);

    // R4
    a_r4_wake_needs_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(powered_down_i));

    // R5
    a_r5_prech_to_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (refresh_o && pend_q) |-> (gap_q == GP_W'(PRECH_CYC)));

    // R6
    a_r6_rfc_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_ok_o |-> (since_ref_q == SR_SAT));

endmodule

bind dram_refresh_seq ref_seq_chk #(
    .PRECH_CYC (PRECH_CYC),
    .RFC_CYC   (RFC_CYC)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .powered_down_i (powered_down_i),
    .wake_o         (wake_o),
    .prech_all_o    (prech_all_o),
    .refresh_o      (refresh_o),
    .burst_ok_o     (burst_ok_o)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;

    localparam int INTERVAL = 40;
    localparam int PRECH    = 3;
    localparam int RFC      = 8;
    localparam int OW       = 4;

    localparam int K_WAKE  = 1;
    localparam int K_PRECH = 2;
    localparam int K_REF   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] outstanding = '0;
    logic          banks_open = 1'b0;
    logic          pd = 1'b0;
    logic          sref_req = 1'b0;
    logic          srx_done = 1'b0;
    logic          wake, prech, refr, burst_ok;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int    exp_kind[$];
    int    exp_cyc[$];
    string exp_req[$];

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .INTERVAL_CYC (INTERVAL),
        .PRECH_CYC    (PRECH),
        .RFC_CYC      (RFC),
        .OUT_W        (OW)
    ) dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .outstanding_i    (outstanding),
        .banks_open_i     (banks_open),
        .powered_down_i   (pd),
        .sref_req_i       (sref_req),
        .sref_exit_done_i (srx_done),
        .wake_o           (wake),
        .prech_all_o      (prech),
        .refresh_o        (refr),
        .burst_ok_o       (burst_ok)
    );

    always_ff @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    task automatic chk(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic push(int kind, int at, string req);
        exp_kind.push_back(kind);
        exp_cyc.push_back(at);
        exp_req.push_back(req);
    endtask

    task automatic observe(int kind);
        if (exp_kind.size() == 0) begin
            chk("R9", "unexpected command kind", kind, 0);
        end else begin
            int    k = exp_kind.pop_front();
            int    c = exp_cyc.pop_front();
            string r = exp_req.pop_front();
            chk(r, "command kind", kind, k);
            chk(r, "command cycle", cyc, c);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wake)  observe(K_WAKE);
            if (prech) observe(K_PRECH);
            if (refr)  observe(K_REF);
        end
    end

    task automatic burst_window(int r);
        wait_cyc(r + RFC);
        chk("R6", "burst_ok during refresh time", int'(burst_ok), 0);
        wait_cyc(r + RFC + 1);
        chk("R6", "burst_ok after refresh time", int'(burst_ok), 1);
    endtask

    initial begin
        int d;
        int r;
        repeat (3) @(negedge clk);
        chk("R1", "burst_ok in reset", int'(burst_ok), 1);
        chk("R1", "commands in reset", int'(wake | prech | refr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "burst_ok after release", int'(burst_ok), 1);

        // quiet rank: first refresh
        d = INTERVAL;
        push(K_REF, d + 2, "R2");
        wait_cyc(d - 1);
        chk("R8", "burst_ok before drain", int'(burst_ok), 1);
        wait_cyc(d);
        chk("R8", "burst_ok in drain", int'(burst_ok), 0);
        r = d + 2;
        burst_window(r);
        d = r + INTERVAL;

        // open banks
        banks_open = 1'b1;
        push(K_PRECH, d + 2, "R5");
        push(K_REF, d + 2 + PRECH, "R5");
        wait_cyc(d + 3);
        banks_open = 1'b0;
        r = d + 2 + PRECH;
        burst_window(r);
        d = r + INTERVAL;

        // late drain
        outstanding = 4'd3;
        push(K_REF, d + 6, "R3");
        wait_cyc(d + 2);
        chk("R8", "burst_ok while draining", int'(burst_ok), 0);
        wait_cyc(d + 4);
        outstanding = '0;
        r = d + 6;
        burst_window(r);
        d = r + INTERVAL;

        // powered down
        pd = 1'b1;
        push(K_WAKE, d + 1, "R4");
        push(K_REF, d + 4, "R4");
        wait_cyc(d + 3);
        pd = 1'b0;
        r = d + 4;
        burst_window(r);
        d = r + INTERVAL;

        // powered down with open banks
        pd = 1'b1;
        banks_open = 1'b1;
        push(K_WAKE, d + 1, "R4");
        push(K_PRECH, d + 6, "R5");
        push(K_REF, d + 6 + PRECH, "R5");
        wait_cyc(d + 5);
        pd = 1'b0;
        wait_cyc(d + 7);
        banks_open = 1'b0;
        r = d + 6 + PRECH;
        burst_window(r);
        d = r + INTERVAL;

        // self-refresh after the refresh
        sref_req = 1'b1;
        push(K_REF, d + 2, "R7");
        r = d + 2;
        push(K_REF, r + RFC + 9, "R7");
        wait_cyc(r + RFC + 1);
        sref_req = 1'b0;
        chk("R7", "burst_ok in self-refresh", int'(burst_ok), 0);
        wait_cyc(r + RFC + 6);
        chk("R7", "burst_ok awaiting exit", int'(burst_ok), 0);
        srx_done = 1'b1;
        wait_cyc(r + RFC + 7);
        srx_done = 1'b0;
        r = r + RFC + 9;
        burst_window(r);

        // interval measured from the last refresh
        d = r + INTERVAL;
        push(K_REF, d + 2, "R10");
        wait_cyc(d + 6);
        chk("R10", "pending expected commands", exp_kind.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule